// File: doc/BRIEF.md
# Dual-Tone Matched Filter Correlator

This block is the fixed-point front end of a two-tone audio FSK demodulator. It takes one signed audio sample per strobe at a fixed sample rate (22050 Hz by default). It keeps a sliding window exactly one symbol long. Against that window it runs two complex correlators in parallel, one tuned to the mark tone and one tuned to the space tone. Each correlator is a matched filter for its tone: a time-reversed, conjugated complex exponential scaled by 2/N. The taps are computed at elaboration from the tone frequency, the sample rate and the window length, so no table is written out.

After each accepted sample, the block registers three results: the squared magnitude of each correlator, and a signed soft symbol equal to mark energy minus space energy. A downstream symbol-timing and slicing stage picks the output at its chosen instants. The output qualifier rises only after a full window of samples has been taken in.

Top module: `dual_tone_correlator`

## Requirements
- R1: While reset is low, and in the first cycle after an asynchronous reset, `outValid` is 0 and `markEnergy`, `spaceEnergy` and `softOut` are all zero. Reset also empties the sample window.
- R2: The window length N is floor(FS_HZ / baud), with a baud rate of 520.83; N is 42 at 22050 Hz. The sample of age m (m = 0 is the sample arriving with the current strobe) is weighted by round(2^15 * (2/N) * cos(theta)) in the real part and by round(-2^15 * (2/N) * sin(theta)) in the imaginary part, where theta = 2*pi*f*(N-1-m)/FS_HZ.
- R3: Each energy output equals re*re + im*im of its correlator, exactly and with no wrap, for any input sequence including full-scale values of +32767 and -32768.
- R4: `softOut` equals markEnergy - spaceEnergy as a signed value, so it is positive for a mark-tone input.
- R5: `outValid` is never high before N strobed samples have been accepted since reset. It is high after the Nth such sample and after every later one.
- R6: Each result appears in the cycle after its `sampleValid` strobe. `outValid` is high only in the cycle after a strobe.
- R7: In a cycle with `sampleValid` low, the window and all three result outputs keep their values.
- R8: The mark tone is 2083.3 Hz and the space tone is 1562.5 Hz. A space-tone input drives `softOut` negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Strobe: `sampleIn` holds a new sample |
| sampleIn | input | 16 | Signed audio sample |
| outValid | output | 1 | Results were updated from a full window |
| markEnergy | output | 76 | Squared magnitude of the mark correlator |
| spaceEnergy | output | 76 | Squared magnitude of the space correlator |
| softOut | output | 77 | Signed mark minus space energy |

## Verification
A wrong coefficient, a misordered window slot or a dropped shift corrupts both energy outputs in the very cycle after the next strobe. It stays visible for as long as the bad sample remains in the window, which is N strobes. A fill counter that is off by one moves the first rise of `outValid` by one strobe. A strobe that is not held off by `sampleValid` shows up as energies that change in a cycle that follows no strobe. The reference model recomputes every correlation from its own history of samples and compares all outputs on every clock, so each of these faults is reported at the first cycle where it shows.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef struct packed {
    logic shift;   // accept sample: advance window, register results
    logic primed;  // this sample completes (or follows) a full window
  } ctlStrobe_t;

  localparam real PI = 3.14159265358979323846;

  // Window length: floor(fs / baud), with baud given in centi-hertz
  function automatic int tapCount(input int fsHz, input int baudCentiHz);
    return (fsHz * 100) / baudCentiHz;
  endfunction

  // Q(coefW-1) coefficient of the conjugated, time-reversed cisoid scaled by 2/N
  function automatic int tapCoef(input int nTaps, input int toneDhz, input int fsHz,
                                 input int coefW, input int k, input bit wantImag);
    longint num;
    real ang, x2, term, c, s, scale;
    num = (longint'(toneDhz) * longint'(nTaps - 1 - k)) % (longint'(fsHz) * 10);
    ang = 2.0 * PI * real'(num) / (real'(fsHz) * 10.0);
    if (ang > PI) ang = ang - 2.0 * PI;
    x2 = ang * ang;
    term = 1.0;
    c = 1.0;
    for (int i = 1; i <= 14; i++) begin
      term = -term * x2 / real'((2 * i - 1) * (2 * i));
      c = c + term;
    end
    term = ang;
    s = ang;
    for (int i = 1; i <= 14; i++) begin
      term = -term * x2 / real'((2 * i) * (2 * i + 1));
      s = s + term;
    end
    scale = real'(longint'(1) << (coefW - 1)) * 2.0 / real'(nTaps);
    if (wantImag) return int'(-scale * s);
    return int'(scale * c);
  endfunction

endpackage

// File: rtl/dtc_correlator.sv
module dtc_correlator #(
  parameter int NTAPS    = 42,
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 16,
  parameter int ACC_W    = 38,
  parameter int ENERGY_W = 76,
  parameter int TONE_DHZ = 20833,
  parameter int FS_HZ    = 22050
) (
  input  logic signed [SAMPLE_W-1:0] win [NTAPS],
  output logic        [ENERGY_W-1:0] energy
);

  logic signed [COEF_W-1:0] coefRe [NTAPS];
  logic signed [COEF_W-1:0] coefIm [NTAPS];
  logic signed [ACC_W-1:0] accRe;
  logic signed [ACC_W-1:0] accIm;
  logic signed [ENERGY_W-1:0] sqRe;
  logic signed [ENERGY_W-1:0] sqIm;

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    localparam int C_RE = dtc_pkg::tapCoef(NTAPS, TONE_DHZ, FS_HZ, COEF_W, k, 1'b0);
    localparam int C_IM = dtc_pkg::tapCoef(NTAPS, TONE_DHZ, FS_HZ, COEF_W, k, 1'b1);
    assign coefRe[k] = COEF_W'(C_RE);
    assign coefIm[k] = COEF_W'(C_IM);
  end

  always_comb begin
    accRe = '0;
    accIm = '0;
    for (int k = 0; k < NTAPS; k++) begin
      accRe = accRe + ACC_W'(win[k]) * ACC_W'(coefRe[k]);
      accIm = accIm + ACC_W'(win[k]) * ACC_W'(coefIm[k]);
    end
    sqRe = ENERGY_W'(accRe) * ENERGY_W'(accRe);
    sqIm = ENERGY_W'(accIm) * ENERGY_W'(accIm);
    energy = $unsigned(sqRe + sqIm);
  end

endmodule

// File: rtl/dtc_control.sv
module dtc_control #(
  parameter int NTAPS = 42,
  localparam int CNT_W = $clog2(NTAPS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  output dtc_pkg::ctlStrobe_t strb,
  output logic                outValid
);

  logic [CNT_W-1:0] fillCnt;
  logic windowFull;

  assign windowFull  = (fillCnt == CNT_W'(NTAPS - 1));
  assign strb.shift  = sampleValid;
  assign strb.primed = sampleValid && windowFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strb.primed;
      if (sampleValid && !windowFull) fillCnt <= fillCnt + 1'b1;
    end
  end

  // R6: a result qualifier is always the echo of a strobe
  p_valid_after_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(sampleValid));

  // R5: the fill count advances only on accepted samples
  p_fill_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(fillCnt));

  // R5: qualifier needs a complete window one cycle earlier
  p_valid_needs_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!windowFull) |=> !outValid);

endmodule

// File: rtl/dtc_datapath.sv
module dtc_datapath #(
  parameter int NTAPS     = 42,
  parameter int SAMPLE_W  = 16,
  parameter int COEF_W    = 16,
  parameter int ACC_W     = 38,
  parameter int ENERGY_W  = 76,
  parameter int SOFT_W    = 77,
  parameter int MARK_DHZ  = 20833,
  parameter int SPACE_DHZ = 15625,
  parameter int FS_HZ     = 22050
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dtc_pkg::ctlStrobe_t        strb,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic        [ENERGY_W-1:0] markEnergy,
  output logic        [ENERGY_W-1:0] spaceEnergy,
  output logic signed [SOFT_W-1:0]   softOut
);

  logic signed [SAMPLE_W-1:0] hist [NTAPS-1];
  logic signed [SAMPLE_W-1:0] win  [NTAPS];
  logic [ENERGY_W-1:0] toneEnergy [2];

  always_comb begin
    win[0] = sampleIn;
    for (int i = 1; i < NTAPS; i++) win[i] = hist[i-1];
  end

  for (genvar t = 0; t < 2; t++) begin : g_tone
    dtc_correlator #(
      .NTAPS   (NTAPS),
      .SAMPLE_W(SAMPLE_W),
      .COEF_W  (COEF_W),
      .ACC_W   (ACC_W),
      .ENERGY_W(ENERGY_W),
      .TONE_DHZ((t == 0) ? MARK_DHZ : SPACE_DHZ),
      .FS_HZ   (FS_HZ)
    ) u_corr (
      .win   (win),
      .energy(toneEnergy[t])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NTAPS - 1; i++) hist[i] <= '0;
      markEnergy  <= '0;
      spaceEnergy <= '0;
      softOut     <= '0;
    end else if (strb.shift) begin
      hist[0] <= sampleIn;
      for (int i = 1; i < NTAPS - 1; i++) hist[i] <= hist[i-1];
      markEnergy  <= toneEnergy[0];
      spaceEnergy <= toneEnergy[1];
      softOut     <= $signed({1'b0, toneEnergy[0]}) - $signed({1'b0, toneEnergy[1]});
    end
  end

  // R7: no strobe, no movement of results
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> ($stable(markEnergy) && $stable(spaceEnergy) && $stable(softOut)));

  // R2: the newest window slot takes the strobed sample
  p_window_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> (hist[0] == $past(sampleIn)));

  // R4: sign of the soft symbol agrees with the two energies
  p_soft_sign_r4: assert property (@(posedge clk) disable iff (!rstN)
    softOut[SOFT_W-1] == (spaceEnergy > markEnergy));

endmodule

// File: rtl/dual_tone_correlator.sv
module dual_tone_correlator #(
  parameter int FS_HZ     = 22050,
  parameter int BAUD_CHZ  = 52083,
  parameter int MARK_DHZ  = 20833,
  parameter int SPACE_DHZ = 15625,
  parameter int SAMPLE_W  = 16,
  parameter int COEF_W    = 16,
  localparam int NTAPS    = dtc_pkg::tapCount(FS_HZ, BAUD_CHZ),
  localparam int ACC_W    = SAMPLE_W + COEF_W + $clog2(NTAPS),
  localparam int ENERGY_W = 2 * ACC_W,
  localparam int SOFT_W   = ENERGY_W + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic                       outValid,
  output logic        [ENERGY_W-1:0] markEnergy,
  output logic        [ENERGY_W-1:0] spaceEnergy,
  output logic signed [SOFT_W-1:0]   softOut
);

  dtc_pkg::ctlStrobe_t strb;

  dtc_control #(.NTAPS(NTAPS)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .strb       (strb),
    .outValid   (outValid)
  );

  dtc_datapath #(
    .NTAPS    (NTAPS),
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .ACC_W    (ACC_W),
    .ENERGY_W (ENERGY_W),
    .SOFT_W   (SOFT_W),
    .MARK_DHZ (MARK_DHZ),
    .SPACE_DHZ(SPACE_DHZ),
    .FS_HZ    (FS_HZ)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .sampleIn   (sampleIn),
    .markEnergy (markEnergy),
    .spaceEnergy(spaceEnergy),
    .softOut    (softOut)
  );

  // R1: the cycle after reset shows an empty, unqualified result
  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (!outValid && markEnergy == '0 && spaceEnergy == '0 && softOut == '0));

endmodule

// File: tb/dual_tone_correlator_bench.sv
`timescale 1ns/1ps
module dual_tone_correlator_bench;

  localparam int NT = 42;        // floor(22050 / 520.83)
  localparam int EW = 76;
  localparam int SW = 77;
  localparam real FS = 22050.0;
  localparam real FMARK = 2083.3;
  localparam real FSPACE = 1562.5;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic outValid;
  logic [EW-1:0] markEnergy;
  logic [EW-1:0] spaceEnergy;
  logic signed [SW-1:0] softOut;

  always #2.5 clk = ~clk;

  dual_tone_correlator u_dual_tone_correlator (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .outValid(outValid), .markEnergy(markEnergy), .spaceEnergy(spaceEnergy),
    .softOut(softOut)
  );

  int vectors = 0;
  int fails = 0;
  string curReq = "R1";
  int coefRe [2][NT];
  int coefIm [2][NT];
  int hist [$];
  int fillCount = 0;
  bit expValid = 1'b0;
  logic signed [127:0] expMark = '0;
  logic signed [127:0] expSpace = '0;
  int unsigned seed = 32'h1234_5678;

  function automatic logic signed [127:0] energyOf(input int t);
    longint re = 0;
    longint im = 0;
    logic signed [127:0] r, i;
    for (int m = 0; m < NT; m++) begin
      re += longint'(hist[m]) * coefRe[t][m];
      im += longint'(hist[m]) * coefIm[t][m];
    end
    r = re;
    i = im;
    return r * r + i * i;
  endfunction

  task automatic compare();
    logic signed [127:0] expSoft;
    expSoft = expMark - expSpace;
    vectors++;
    if (outValid !== expValid || markEnergy !== expMark[EW-1:0] ||
        spaceEnergy !== expSpace[EW-1:0] || softOut !== expSoft[SW-1:0]) begin
      fails++;
      $display("FAIL %s: valid/mark/space/soft got %0b %0d %0d %0d expected %0b %0d %0d %0d",
               curReq, outValid, markEnergy, spaceEnergy, softOut,
               expValid, expMark[EW-1:0], expSpace[EW-1:0], $signed(expSoft[SW-1:0]));
    end
  endtask

  task automatic clearModel();
    hist.delete();
    for (int m = 0; m < NT - 1; m++) hist.push_back(0);
    fillCount = 0;
    expValid = 1'b0;
    expMark = '0;
    expSpace = '0;
  endtask

  // one clock: check last result, then drive this cycle's inputs and advance the model
  task automatic step(input bit rstAct, input bit v, input int s);
    @(negedge clk);
    compare();
    rstN = !rstAct;
    sampleValid = v;
    sampleIn = 16'(s);
    if (rstAct) clearModel();
    else if (v) begin
      hist.push_front(s);
      fillCount++;
      expValid = (fillCount >= NT);
      expMark = energyOf(0);
      expSpace = energyOf(1);
      void'(hist.pop_back());
    end else expValid = 1'b0;
  endtask

  task automatic checkSign(input string req, input bit wantPositive);
    vectors++;
    if (wantPositive ? !(softOut > 0) : !(softOut < 0)) begin
      fails++;
      $display("FAIL %s: soft sign got %0d expected %s", req, softOut,
               wantPositive ? "positive" : "negative");
    end
  endtask

  task automatic checkValid(input string req, input bit want);
    vectors++;
    if (outValid !== want) begin
      fails++;
      $display("FAIL %s: outValid got %0b expected %0b", req, outValid, want);
    end
  endtask

  function automatic int toneSample(input real f, input int n, input real amp);
    return int'(amp * $sin(TWO_PI * f * real'(n) / FS));
  endfunction

  function automatic int nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[30:15]));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int t = 0; t < 2; t++)
      for (int m = 0; m < NT; m++) begin
        real ang;
        ang = TWO_PI * (t == 0 ? FMARK : FSPACE) * real'(NT - 1 - m) / FS;
        coefRe[t][m] = int'(32768.0 * 2.0 / real'(NT) * $cos(ang));
        coefIm[t][m] = int'(-32768.0 * 2.0 / real'(NT) * $sin(ang));
      end
    clearModel();

    // R1: reset state
    curReq = "R1";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 0);
    step(1'b0, 1'b0, 0);
    checkValid("R1", 1'b0);

    // R5: fill with mark tone; qualifier rises after the Nth strobe only
    curReq = "R5";
    for (int n = 0; n < NT - 1; n++) step(1'b0, 1'b1, toneSample(FMARK, n, 20000.0));
    step(1'b0, 1'b0, 0);
    checkValid("R5", 1'b0);
    step(1'b0, 1'b1, toneSample(FMARK, NT - 1, 20000.0));
    step(1'b0, 1'b0, 0);
    checkValid("R5", 1'b1);

    // R2 and R4: steady mark tone, soft symbol positive
    curReq = "R2";
    for (int n = NT; n < NT + 90; n++) step(1'b0, 1'b1, toneSample(FMARK, n, 30000.0));
    step(1'b0, 1'b0, 0);
    checkSign("R4", 1'b1);

    // R8: space tone, soft symbol negative
    curReq = "R8";
    for (int n = 0; n < 90; n++) step(1'b0, 1'b1, toneSample(FSPACE, n, 30000.0));
    step(1'b0, 1'b0, 0);
    checkSign("R8", 1'b0);

    // R3: full-scale patterns
    curReq = "R3";
    for (int n = 0; n < 60; n++) step(1'b0, 1'b1, (n % 2 == 0) ? 32767 : -32768);
    for (int n = 0; n < 50; n++) step(1'b0, 1'b1, -32768);
    for (int n = 0; n < 50; n++) step(1'b0, 1'b1, ((n / 3) % 2 == 0) ? 32767 : -32768);

    // R7 and R6: irregular strobes with random data and holds between them
    curReq = "R7";
    for (int n = 0; n < 240; n++) step(1'b0, (n % 3) != 0 && (n % 7) != 5, nextRand());
    curReq = "R6";
    for (int n = 0; n < 60; n++) step(1'b0, n[0], toneSample(FMARK, n, 25000.0));

    // R1 and R5: reset in mid-stream clears the window and restarts the fill
    curReq = "R1";
    step(1'b1, 1'b0, 0);
    step(1'b1, 1'b1, 1234);
    curReq = "R5";
    for (int n = 0; n < NT + 20; n++) step(1'b0, 1'b1, toneSample(FSPACE, n, 28000.0));
    step(1'b0, 1'b0, 0);
    step(1'b0, 1'b0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule